// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of words between an I/O device data port and memory without the processor touching each word. Software programs a start address and a word count over a small register bus. It then writes a control word that sets the direction and the bus mode and launches the run. The engine asks for the memory bus with a request line and moves one word in each cycle where the request is granted. It steps the working address up by one and the remaining count down by one for every word moved. When the count reaches zero it raises an interrupt line, and that line stays high until the processor acknowledges it.

Two bus modes exist. In the interleaved mode the request drops for one cycle after every word, so other masters may use the bus between words. In the burst mode the request stays high until the whole block has moved. Memory is taken to answer in the same cycle it is granted: write data is taken in the grant cycle, and read data is valid in the grant cycle.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `dmar` and `intr` are low and the status word (register select 2) reads zero.
- R2: Register select 0 reads back the working address and select 1 reads back the remaining count. A control write (select 2) with bit 0 (start) set and a nonzero count makes status bit 0 (busy) high and raises `dmar` right after that write.
- R3: While `dmar` is high and `dmaa` is low, no word moves, the count holds and `dmar` stays high.
- R4: Each cycle with `dmar` and `dmaa` both high moves one word at `mem_addr` equal to the working address. The address then rises by one and the count falls by one. Control bit 1 selects the direction: 0 moves device data into memory with `mem_we` high, and 1 moves memory data to the device.
- R5: In the interleaved mode (control bit 2 = 0), `dmar` is low for the cycle after each moved word, so a block of N words gives N rising edges of `dmar`.
- R6: In the burst mode (control bit 2 = 1), `dmar` stays high from the start until the last word, giving one rising edge per block.
- R7: On the cycle after the last word, busy (status bit 0) is low, done (bit 1) is high and `intr` (also status bit 3) is high.
- R8: `intr` stays high while `inta` is low and drops on the cycle after `inta` is high.
- R9: A start with a zero count sets done and `intr` on the next cycle and never raises `dmar`.
- R10: While busy, writes to the address and count registers are ignored and a start sets error (status bit 2) without disturbing the run. Any control write while idle clears done and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data for the selected register |
| dmar | output | 1 | Memory bus request |
| dmaa | input | 1 | Memory bus grant |
| mem_addr | output | W | Memory word address |
| mem_we | output | 1 | Memory write enable (valid in granted cycles) |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Data read from memory |
| dev_strobe | output | 1 | Device word strobe, one per moved word |
| dev_wdata | output | DW | Data sent to the device |
| dev_rdata | input | DW | Data supplied by the device |
| intr | output | 1 | Completion interrupt request |
| inta | input | 1 | Interrupt acknowledge |

## Verification
A wrong working address or count shows in the first granted cycle: a word lands at the wrong memory location or a word is missing from the device stream, and the address and count read back at the end are off. A wrong mode or gap flag shows in the number of rising edges of `dmar` within one block. A lost or early completion shows one cycle after the last word, when `intr` and the done bit are sampled. The bench stalls the grant, writes registers during a run and starts with a zero count, so that stray state shows up at the ports within a few cycles.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int W  = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          dmar,
  input  logic          dmaa,
  output logic [W-1:0]  mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_strobe,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  output logic          intr,
  input  logic          inta
);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  logic [W-1:0] addr_q, cnt_q;
  logic busy, done, err, dir_q, burst_q, gap;
  logic xfer, ctrl_wr, start;
  logic [W-1:0] status;

  assign dmar       = busy & ~gap;
  assign xfer       = dmar & dmaa;
  assign mem_addr   = addr_q;
  assign mem_we     = xfer & ~dir_q;
  assign mem_wdata  = dev_rdata;
  assign dev_wdata  = mem_rdata;
  assign dev_strobe = xfer;
  assign ctrl_wr    = reg_wr && reg_sel == SEL_CTRL;
  assign start      = ctrl_wr & reg_wdata[0];
  assign status     = {{(W-6){1'b0}}, burst_q, dir_q, intr, err, done, busy};

  always_comb begin
    case (reg_sel)
      SEL_ADDR: reg_rdata = addr_q;
      SEL_CNT:  reg_rdata = cnt_q;
      SEL_CTRL: reg_rdata = status;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      gap     <= 1'b0;
      intr    <= 1'b0;
    end else begin
      if (inta) intr <= 1'b0;
      gap <= 1'b0;
      if (!busy) begin
        if (reg_wr && reg_sel == SEL_ADDR) addr_q <= reg_wdata;
        if (reg_wr && reg_sel == SEL_CNT)  cnt_q  <= reg_wdata;
        if (ctrl_wr) begin
          done    <= 1'b0;
          err     <= 1'b0;
          dir_q   <= reg_wdata[1];
          burst_q <= reg_wdata[2];
          if (start) begin
            if (cnt_q == '0) begin
              done <= 1'b1;
              intr <= 1'b1;
            end else begin
              busy <= 1'b1;
            end
          end
        end
      end else begin
        if (start) err <= 1'b1;
        if (xfer) begin
          addr_q <= addr_q + W'(1);
          cnt_q  <= cnt_q - W'(1);
          gap    <= ~burst_q;
          if (cnt_q == W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            intr <= 1'b1;
          end
        end
      end
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dmar && !dmaa && !reg_wr) |=> ($stable(cnt_q) && dmar)); // R3

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cnt_q == $past(cnt_q) - W'(1) && addr_q == $past(addr_q) + W'(1))); // R4

  AST_GAP_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !burst_q) |=> !dmar); // R5

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && burst_q && cnt_q != W'(1)) |=> dmar); // R6

  AST_LAST_WORD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cnt_q == W'(1)) |=> (intr && done && !busy)); // R7

  AST_INTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && !inta) |=> intr); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dmar); // R9

endmodule

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic dmar, dmaa, mem_we, dev_strobe, intr;
  logic inta = 1'b0;
  logic grant_en = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;

  always #10 clk = ~clk;

  dma_xfer_engine #(.W(16), .DW(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dmar(dmar), .dmaa(dmaa),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_strobe(dev_strobe), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .intr(intr), .inta(inta));

  assign dmaa = dmar & grant_en;

  logic [15:0] mem [256];
  logic [15:0] sink [64];
  logic [15:0] src_idx, sink_idx;
  int rises = 0;
  logic dmar_prev = 1'b0;
  int checks = 0, fails = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i);
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = 16'hA000 + src_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      src_idx <= '0;
      sink_idx <= '0;
    end else if (dev_strobe) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        src_idx <= src_idx + 16'd1;
      end else begin
        sink[sink_idx[5:0]] <= dev_wdata;
        sink_idx <= sink_idx + 16'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (dmar && !dmar_prev) rises++;
    dmar_prev <= dmar;
  end

  // {addr[17:10], count[9:2], dir[1], burst[0]}
  localparam logic [17:0] VEC [5] = '{
    {8'h10, 8'd5, 1'b0, 1'b0},
    {8'h20, 8'd4, 1'b0, 1'b1},
    {8'h40, 8'd3, 1'b1, 1'b0},
    {8'h48, 8'd6, 1'b1, 1'b1},
    {8'h60, 8'd1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, v);
    chk("R1 status", v, 0);
    chk("R1 dmar", dmar, 0);
    chk("R1 intr", intr, 0);

    for (int k = 0; k < 5; k++) begin
      logic [7:0] a, c;
      logic d, b, seen;
      logic [15:0] s0, k0;
      int r0;
      a = VEC[k][17:10]; c = VEC[k][9:2]; d = VEC[k][1]; b = VEC[k][0];
      @(negedge clk);
      wr(2'd0, {8'h00, a});
      wr(2'd1, {8'h00, c});
      rd(2'd0, v); chk("R2 addr readback", v, {8'h00, a});
      rd(2'd1, v); chk("R2 count readback", v, {8'h00, c});
      s0 = src_idx; k0 = sink_idx; r0 = rises;
      wr(2'd2, {13'd0, b, d, 1'b1});
      rd(2'd2, v); chk("R2 busy after start", v[0], 1);
      chk("R2 dmar after start", dmar, 1);
      reg_sel = 2'd1;
      seen = 1'b0;
      for (int t = 0; t < 500 && !seen; t++) begin
        #1;
        if (dmar && dmaa && reg_rdata == 16'd1) seen = 1'b1;
        @(negedge clk);
      end
      chk("R7 intr after last word", intr, 1);
      rd(2'd2, v); chk("R7 status busy/done/err/intr", v[3:0], 4'b1010);
      rd(2'd0, v); chk("R4 final address", v, {8'h00, a} + {8'h00, c});
      rd(2'd1, v); chk("R4 final count", v, 0);
      chk(b ? "R6 burst request edges" : "R5 interleaved request edges",
          rises - r0, b ? 1 : c);
      for (int i = 0; i < c; i++) begin
        if (!d) chk("R4 device to memory word", mem[8'(a + i)], 16'hA000 + s0 + 16'(i));
        else    chk("R4 memory to device word", sink[6'(k0 + 16'(i))], 16'h5000 + {8'h00, a} + 16'(i));
      end
      inta = 1'b1;
      @(negedge clk);
      inta = 1'b0;
      chk("R8 intr cleared by inta", intr, 0);
    end

    // stalled grant, writes during a run, start while busy
    grant_en = 1'b0;
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0001);
    repeat (5) @(negedge clk);
    chk("R3 dmar held while not granted", dmar, 1);
    rd(2'd1, v); chk("R3 count held while not granted", v, 2);
    wr(2'd0, 16'h0099);
    rd(2'd0, v); chk("R10 address write ignored while busy", v, 16'h0080);
    wr(2'd1, 16'd7);
    rd(2'd1, v); chk("R10 count write ignored while busy", v, 2);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R10 error and busy after restart", v[2:0], 3'b101);
    grant_en = 1'b1;
    for (int t = 0; t < 100 && !intr; t++) @(negedge clk);
    rd(2'd0, v); chk("R10 run undisturbed address", v, 16'h0082);
    repeat (10) @(negedge clk);
    chk("R8 intr held without inta", intr, 1);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;

    // zero count start
    begin
      int r0;
      wr(2'd1, 16'd0);
      r0 = rises;
      wr(2'd2, 16'h0001);
      rd(2'd2, v); chk("R9 zero count done/intr, err cleared", v[3:0], 4'b1010);
      chk("R9 intr at once", intr, 1);
      repeat (5) @(negedge clk);
      chk("R9 no bus request", rises - r0, 0);
      wr(2'd2, 16'h0000);
      rd(2'd2, v); chk("R10 idle control write clears done", v[1], 0);
    end
    finish_run();
  end
endmodule